// File: doc/BRIEF.md
# Dual-Channel Indirect Register File

This block sits between a host bus and the two serial engines of a dual-channel serial controller. Each channel exposes a byte-wide control port and a byte-wide data port. Most registers are reached in two steps: a write to the control port while the channel's pointer is zero is a command write, and its low bits load the pointer; the next control-port access reads or writes the register the pointer selects, and the pointer then drops back to zero. The data port reaches the transmit and receive data bytes directly and never disturbs the pointer.

The block stores the per-channel write registers and two registers shared by both channels: the interrupt vector and the master interrupt control. It maps the read addresses onto engine status inputs, stored values and readback aliases. Command fields carried inside certain writes are not stored. They leave the block as one-cycle pulses with a code. The serial engines, baud generator and clock recovery loop are outside the block: their status arrives as input bytes and their commands leave as strobes.

All host accesses are single-cycle. `acc_rdata` is combinational and is valid in the cycle of a read. Every strobe output is registered and is high for exactly the one cycle after the access that caused it. The transmit byte is a plain strobe with no back-pressure, because the engine takes one byte per host access and the host paces its own writes. Channel A is channel index 0 and channel B is index 1. Packed per-channel inputs carry channel A in bits 7:0 and channel B in bits 15:8.

Top module: `duo_indirect_regs`

## Requirements
- R1: After reset every stored register and both pointers are zero, and every strobe output is low.
- R2: A control write while the pointer is zero is a command. Its bits 2:0 load the pointer, and when bits 5:3 are 001 the pointer becomes 8 plus bits 2:0. A control read while the pointer is zero returns the channel's status byte 0 input.
- R3: Any control access made while the pointer is nonzero uses the selected register, and the pointer is zero afterwards.
- R4: Write registers 12, 13 and 15 of each channel read back at read addresses 12, 13 and 15 of the same channel, and writing them leaves the other channel's copies unchanged.
- R5: Register 2 (vector) is one value shared by both channels. Read address 2 on channel A returns it. On channel B it returns it unchanged when shared register 9 bit 0 is 0. When that bit is 1, bits 3:1 are replaced by a code for the highest pending interrupt: A rx 110, A tx 100, A ext 101, B rx 010, B tx 000, B ext 001, none 011, in that priority order.
- R6: A write to register 9 pulses `chrst_b` when bits 7:6 are 01, `chrst_a` when they are 10, and `hwrst` when they are 11. Bit 0 is kept in the shared register.
- R7: A write to register 14 with bits 7:5 nonzero pulses `dpll_stb` for that channel, with those bits on `dpll_code`. A value of 000 gives no pulse.
- R8: With register 15 bit 0 clear, a write to address 7 goes to the sync register. With it set, the write goes to the alternate option register.
- R9: With bit 6 of the alternate option register set, read addresses 4, 5, 9 and 11 return write registers 4, 5, 3 and 10. With it clear they read 0. Read address 14 always reads 0.
- R10: Read address 3 on channel A returns `{2'b00, irq_pend}`, with bit 0 B ext, bit 1 B tx, bit 2 B rx, bit 3 A ext, bit 4 A tx, bit 5 A rx. On channel B it reads 0.
- R11: A data-port write, or a control write to register 8, pulses `tx_stb` for that channel with the byte on `tx_byte`. A data-port read, or a control read of address 8, returns that channel's `rx_byte` and pulses `rx_ack`. Data-port accesses leave the pointer unchanged.
- R12: A command write with bits 5:3 in 2..7 pulses `cmd_stb` for the channel with that code on `cmd_code`. Nonzero bits 7:6 pulse `crc_stb` with that value on `crc_code`.
- R13: Read addresses 1, 6, 7 and 10 return the channel's matching status input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Host access in this cycle |
| acc_we | input | 1 | 1 write, 0 read |
| acc_ch | input | 1 | Channel: 0 A, 1 B |
| acc_dport | input | 1 | 1 data port, 0 control port |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte (combinational) |
| stat_rr0 | input | 16 | Status byte 0 per channel |
| stat_rr1 | input | 16 | Special-condition status per channel |
| stat_rr6 | input | 16 | Frame count low per channel |
| stat_rr7 | input | 16 | Frame count high per channel |
| stat_rr10 | input | 16 | Clock recovery status per channel |
| rx_byte | input | 16 | Received byte per channel |
| irq_pend | input | 6 | Pending interrupt sources |
| tx_stb | output | 2 | Transmit byte strobe per channel |
| tx_byte | output | 8 | Transmit byte |
| rx_ack | output | 2 | Received byte consumed, per channel |
| cmd_stb | output | 2 | Command strobe per channel |
| cmd_code | output | 3 | Command code |
| crc_stb | output | 2 | CRC command strobe per channel |
| crc_code | output | 2 | CRC command code |
| dpll_stb | output | 2 | Clock recovery command strobe per channel |
| dpll_code | output | 3 | Clock recovery command code |
| chrst_a | output | 1 | Channel A reset pulse |
| chrst_b | output | 1 | Channel B reset pulse |
| hwrst | output | 1 | Hardware reset pulse |

## Verification
The bench sweeps all 64 pending-interrupt patterns through the channel B vector read and the channel A pending read. A wrong priority chain shows up there as a bad code in bits 3:1, and a missing channel gate shows up as nonzero pending bits on channel B. It walks address 7 under both selector settings and checks the aliased reads on each side. A design that ignored the selector would switch aliasing on from the sync register, or fail to switch it on from the option register. It also mixes data-port accesses between a pointer load and its register access, and issues every command, reset and clock-recovery code. A design that let the data port clear the pointer, or that left the pointer set after an access, would then read the wrong register. Every code is checked for a single correctly routed one-cycle pulse.

// File: rtl/duo_regs_pkg.sv
package duo_regs_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned PTR_W     = 4;
  localparam int unsigned NUM_REGS  = 1 << PTR_W;
  localparam int unsigned PEND_W    = 6;
  localparam int unsigned ALT7_SLOT = 8;   // storage slot reused for the alternate option register
  localparam int unsigned DPLL_KEEP = 5;   // register 14 stores only its low bits

  typedef logic [DATA_W-1:0] byte_t;

  // Highest pending interrupt source encoded for the modified vector.
  function automatic logic [2:0] vec_code(input logic [PEND_W-1:0] p);
    if (p[5])      return 3'b110;
    else if (p[4]) return 3'b100;
    else if (p[3]) return 3'b101;
    else if (p[2]) return 3'b010;
    else if (p[1]) return 3'b000;
    else if (p[0]) return 3'b001;
    else           return 3'b011;
  endfunction

  // Slots that each channel keeps locally (0 is the command, 2 and 9 are shared).
  function automatic bit slot_kept(input int unsigned i);
    return !(i == 0 || i == 2 || i == 9);
  endfunction
endpackage

// File: rtl/duo_chan_bank.sv
module duo_chan_bank import duo_regs_pkg::*; (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ctl_we,
  input  logic                            ctl_re,
  input  byte_t                           wdata,
  output logic [PTR_W-1:0]                ptr_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  localparam logic [PTR_W:0] TGT_NONE = (PTR_W+1)'(NUM_REGS);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W:0]   tgt;
  byte_t            slot_q [NUM_REGS];

  // Address 7 is steered by register 15 bit 0; address 8 is the data byte, never stored.
  always_comb begin
    tgt = {1'b0, ptr_q};
    if (ptr_q == PTR_W'(7) && slot_q[15][0]) tgt = (PTR_W+1)'(ALT7_SLOT);
    else if (ptr_q == PTR_W'(8))             tgt = TGT_NONE;
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      if (slot_kept(i)) begin : g_keep
        localparam byte_t MASK = (i == 14) ? byte_t'((1 << DPLL_KEEP) - 1) : '1;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            slot_q[i] <= '0;
          else if (ctl_we && ptr_q != '0 && tgt == (PTR_W+1)'(i))
            slot_q[i] <= wdata & MASK;
        end
      end else begin : g_none
        assign slot_q[i] = '0;
      end
      assign regs_o[i] = slot_q[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (ctl_we && ptr_q == '0)
      ptr_q <= {wdata[5:3] == 3'b001, wdata[2:0]};
    else if (ctl_we || ctl_re)
      ptr_q <= '0;
  end

  assign ptr_o = ptr_q;

  // R3: a register access always returns the pointer to zero
  a_r3_ptr_return: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_we || ctl_re) && ptr_q != '0) |=> (ptr_q == '0));

  // R2: the pointer only becomes nonzero through a command write
  a_r2_ptr_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr_q) && ptr_q != '0) |-> $past(ctl_we && ptr_q == '0));
endmodule

// File: rtl/duo_read_map.sv
module duo_read_map import duo_regs_pkg::*; #(
  parameter bit IS_B = 1'b0
) (
  input  logic [PTR_W-1:0]                ptr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  byte_t                           vec,
  input  logic                            vec_stat_en,
  input  logic [PEND_W-1:0]               pend,
  input  byte_t                           rr0,
  input  byte_t                           rr1,
  input  byte_t                           rr6,
  input  byte_t                           rr7,
  input  byte_t                           rr10,
  input  byte_t                           rx,
  output byte_t                           rdata
);
  logic  ext;
  byte_t vec_rd;
  byte_t pend_rd;

  assign ext = regs[ALT7_SLOT][6];

  generate
    if (IS_B) begin : g_b
      assign vec_rd  = vec_stat_en ? {vec[7:4], vec_code(pend), vec[0]} : vec;
      assign pend_rd = '0;
    end else begin : g_a
      assign vec_rd  = vec;
      assign pend_rd = byte_t'(pend);
    end
  endgenerate

  always_comb begin
    unique case (ptr)
      4'd0:    rdata = rr0;
      4'd1:    rdata = rr1;
      4'd2:    rdata = vec_rd;
      4'd3:    rdata = pend_rd;
      4'd4:    rdata = ext ? regs[4]  : '0;
      4'd5:    rdata = ext ? regs[5]  : '0;
      4'd6:    rdata = rr6;
      4'd7:    rdata = rr7;
      4'd8:    rdata = rx;
      4'd9:    rdata = ext ? regs[3]  : '0;
      4'd10:   rdata = rr10;
      4'd11:   rdata = ext ? regs[10] : '0;
      4'd12:   rdata = regs[12];
      4'd13:   rdata = regs[13];
      4'd15:   rdata = regs[15];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/duo_indirect_regs.sv
module duo_indirect_regs import duo_regs_pkg::*; (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  logic                     acc_we,
  input  logic                     acc_ch,
  input  logic                     acc_dport,
  input  logic [7:0]               acc_wdata,
  output logic [7:0]               acc_rdata,
  input  logic [15:0]              stat_rr0,
  input  logic [15:0]              stat_rr1,
  input  logic [15:0]              stat_rr6,
  input  logic [15:0]              stat_rr7,
  input  logic [15:0]              stat_rr10,
  input  logic [15:0]              rx_byte,
  input  logic [5:0]               irq_pend,
  output logic [1:0]               tx_stb,
  output logic [7:0]               tx_byte,
  output logic [1:0]               rx_ack,
  output logic [1:0]               cmd_stb,
  output logic [2:0]               cmd_code,
  output logic [1:0]               crc_stb,
  output logic [1:0]               crc_code,
  output logic [1:0]               dpll_stb,
  output logic [2:0]               dpll_code,
  output logic                     chrst_a,
  output logic                     chrst_b,
  output logic                     hwrst
);
  logic [NUM_CH-1:0][PTR_W-1:0]                ptr_all;
  logic [NUM_CH-1:0][NUM_REGS-1:0][DATA_W-1:0] regs_all;
  logic [NUM_CH-1:0][DATA_W-1:0]               map_out;
  logic [NUM_CH-1:0]                           ctl_we_ch, ctl_re_ch;
  byte_t                                       vec_q;
  logic [5:0]                                  mic_q;

  logic             ctl_we, ctl_re, dat_we, dat_re;
  logic [PTR_W-1:0] ptr_sel;
  logic             cmd_we, wr2_we, wr9_we, wr14_we, tx_hit, rx_hit;
  logic [NUM_CH-1:0] ch_hot;

  assign ctl_we  = acc_en &&  acc_we && !acc_dport;
  assign ctl_re  = acc_en && !acc_we && !acc_dport;
  assign dat_we  = acc_en &&  acc_we &&  acc_dport;
  assign dat_re  = acc_en && !acc_we &&  acc_dport;
  assign ptr_sel = ptr_all[acc_ch];
  assign ch_hot  = NUM_CH'(1) << acc_ch;

  assign cmd_we  = ctl_we && ptr_sel == PTR_W'(0);
  assign wr2_we  = ctl_we && ptr_sel == PTR_W'(2);
  assign wr9_we  = ctl_we && ptr_sel == PTR_W'(9);
  assign wr14_we = ctl_we && ptr_sel == PTR_W'(14);
  assign tx_hit  = dat_we || (ctl_we && ptr_sel == PTR_W'(8));
  assign rx_hit  = dat_re || (ctl_re && ptr_sel == PTR_W'(8));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ctl_we_ch[c] = ctl_we && acc_ch == 1'(c);
      assign ctl_re_ch[c] = ctl_re && acc_ch == 1'(c);

      duo_chan_bank i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_we (ctl_we_ch[c]),
        .ctl_re (ctl_re_ch[c]),
        .wdata  (acc_wdata),
        .ptr_o  (ptr_all[c]),
        .regs_o (regs_all[c])
      );

      duo_read_map #(.IS_B(c == 1)) i_map (
        .ptr         (ptr_all[c]),
        .regs        (regs_all[c]),
        .vec         (vec_q),
        .vec_stat_en (mic_q[0]),
        .pend        (irq_pend),
        .rr0         (stat_rr0[c*DATA_W +: DATA_W]),
        .rr1         (stat_rr1[c*DATA_W +: DATA_W]),
        .rr6         (stat_rr6[c*DATA_W +: DATA_W]),
        .rr7         (stat_rr7[c*DATA_W +: DATA_W]),
        .rr10        (stat_rr10[c*DATA_W +: DATA_W]),
        .rx          (rx_byte[c*DATA_W +: DATA_W]),
        .rdata       (map_out[c])
      );
    end
  endgenerate

  assign acc_rdata = acc_dport ? rx_byte[acc_ch*DATA_W +: DATA_W] : map_out[acc_ch];

  // Shared registers: one copy, written from either channel.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      mic_q <= '0;
    end else begin
      if (wr2_we) vec_q <= acc_wdata;
      if (wr9_we) mic_q <= acc_wdata[5:0];
    end
  end

  // One-cycle strobes decoded from the access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_stb <= '0; tx_byte <= '0; rx_ack <= '0;
      cmd_stb <= '0; cmd_code <= '0; crc_stb <= '0; crc_code <= '0;
      dpll_stb <= '0; dpll_code <= '0;
      chrst_a <= 1'b0; chrst_b <= 1'b0; hwrst <= 1'b0;
    end else begin
      tx_stb   <= tx_hit ? ch_hot : '0;
      rx_ack   <= rx_hit ? ch_hot : '0;
      if (tx_hit) tx_byte <= acc_wdata;
      cmd_stb  <= (cmd_we && acc_wdata[5:4] != 2'b00) ? ch_hot : '0;
      if (cmd_we) cmd_code <= acc_wdata[5:3];
      crc_stb  <= (cmd_we && acc_wdata[7:6] != 2'b00) ? ch_hot : '0;
      if (cmd_we) crc_code <= acc_wdata[7:6];
      dpll_stb <= (wr14_we && acc_wdata[7:5] != 3'b000) ? ch_hot : '0;
      if (wr14_we) dpll_code <= acc_wdata[7:5];
      chrst_b  <= wr9_we && acc_wdata[7:6] == 2'b01;
      chrst_a  <= wr9_we && acc_wdata[7:6] == 2'b10;
      hwrst    <= wr9_we && acc_wdata[7:6] == 2'b11;
    end
  end

  // R11: at most one channel gets a transmit byte per cycle, and only after a write
  a_r11_tx_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tx_stb));
  a_r11_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stb != '0) |-> $past(acc_en && acc_we));
  // R6: reset commands are mutually exclusive
  a_r6_reset_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chrst_a, chrst_b, hwrst}));
  // R5: the shared vector only changes after a register 2 write
  a_r5_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr2_we) |-> $stable(vec_q));
  // R7: a clock recovery strobe follows a register 14 write
  a_r7_dpll_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (dpll_stb != '0) |-> $past(wr14_we));
endmodule

// File: tb/test_duo_indirect_regs.sv
`timescale 1ns/1ps
module test_duo_indirect_regs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0, acc_ch = 1'b0, acc_dport = 1'b0;
  logic [7:0]  acc_wdata = '0, acc_rdata;
  logic [15:0] stat_rr0 = 16'hB0A0, stat_rr1 = 16'hB1A1, stat_rr6 = 16'hB6A6;
  logic [15:0] stat_rr7 = 16'hB7A7, stat_rr10 = 16'hBAAA, rx_byte = 16'hC4D3;
  logic [5:0]  irq_pend = '0;
  logic [1:0]  tx_stb, rx_ack, cmd_stb, crc_stb, dpll_stb, crc_code;
  logic [7:0]  tx_byte;
  logic [2:0]  cmd_code, dpll_code;
  logic        chrst_a, chrst_b, hwrst;

  always #2.5 clk = ~clk;

  duo_indirect_regs i_duo_indirect_regs (.*);

  int checks = 0, fails = 0;
  logic [7:0] last_rd;
  logic [1:0] p_tx, p_rx, p_cmd, p_crc, p_dpll, p_crcc;
  logic [7:0] p_txb;
  logic [2:0] p_cmdc, p_dpllc;
  logic       p_ra, p_rb, p_hw;
  logic [7:0] model [2][16];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit ch, input bit dp, input bit we, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = we; acc_ch = ch; acc_dport = dp; acc_wdata = d;
    #1 last_rd = acc_rdata;
    @(posedge clk);
    #1;
    acc_en = 1'b0;
    p_tx = tx_stb; p_txb = tx_byte; p_rx = rx_ack; p_cmd = cmd_stb; p_cmdc = cmd_code;
    p_crc = crc_stb; p_crcc = crc_code; p_dpll = dpll_stb; p_dpllc = dpll_code;
    p_ra = chrst_a; p_rb = chrst_b; p_hw = hwrst;
  endtask

  task automatic point(input bit ch, input int addr);
    logic [7:0] a;
    a = 8'(addr);
    acc(ch, 1'b0, 1'b1, (addr >= 8) ? (8'h08 | (a & 8'h07)) : a);
  endtask

  task automatic wreg(input bit ch, input int addr, input logic [7:0] v);
    if (addr != 0) point(ch, addr);
    acc(ch, 1'b0, 1'b1, v);
  endtask

  task automatic rreg(input bit ch, input int addr, output logic [7:0] v);
    if (addr != 0) point(ch, addr);
    acc(ch, 1'b0, 1'b0, 8'h00);
    v = last_rd;
  endtask

  function automatic logic [2:0] exp_code(input logic [5:0] p);
    logic [2:0] r;
    r = 3'b011;
    for (int b = 0; b < 6; b++)
      if (p[b]) r = (b == 0) ? 3'b001 : (b == 1) ? 3'b000 : (b == 2) ? 3'b010 :
                    (b == 3) ? 3'b101 : (b == 4) ? 3'b100 : 3'b110;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int regs3 [3];
    regs3 = '{12, 13, 15};
    for (int c = 0; c < 2; c++) for (int r = 0; r < 16; r++) model[c][r] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check("R1 strobes", {tx_stb, rx_ack, cmd_stb, crc_stb, dpll_stb, chrst_a, chrst_b, hwrst}, '0);
    rreg(0, 12, v); check("R1 rr12 A", v, 0);
    rreg(1, 15, v); check("R1 rr15 B", v, 0);
    rreg(1, 13, v); check("R1 rr13 B", v, 0);

    // R4: readback sweep with cross-channel isolation
    for (int k = 0; k < 3; k++)
      for (int c = 0; c < 2; c++)
        foreach (regs3[j]) begin
          logic [7:0] w;
          w = 8'(c * 8'h35 + regs3[j] * 8'h11 + k * 8'h47);
          wreg(c[0], regs3[j], w);
          model[c][regs3[j]] = w;
          rreg(c[0], regs3[j], v); check("R4 readback", v, w);
          rreg(!c[0], regs3[j], v); check("R4 isolation", v, model[1-c][regs3[j]]);
        end
    wreg(0, 15, 8'h00); model[0][15] = 8'h00;
    wreg(1, 15, 8'h00); model[1][15] = 8'h00;

    // R3: after a register read the next control read is status 0
    rreg(0, 12, v);
    acc(0, 1'b0, 1'b0, 8'h00); check("R3 ptr cleared", last_rd, 8'hA0);

    // R8 / R9: selector and aliases
    wreg(0, 15, 8'h01);
    wreg(0, 7, 8'h40);
    wreg(0, 15, 8'h00);
    wreg(0, 4, 8'hA5); wreg(0, 5, 8'h5A); wreg(0, 3, 8'h3C); wreg(0, 10, 8'hC3);
    rreg(0, 4, v);  check("R9 rr4 alias", v, 8'hA5);
    rreg(0, 5, v);  check("R9 rr5 alias", v, 8'h5A);
    rreg(0, 9, v);  check("R9 rr9 alias", v, 8'h3C);
    rreg(0, 11, v); check("R9 rr11 alias", v, 8'hC3);
    rreg(0, 14, v); check("R9 rr14 zero", v, 8'h00);
    wreg(0, 7, 8'h00);
    rreg(0, 4, v);  check("R8 sync write keeps option", v, 8'hA5);
    wreg(1, 4, 8'h11);
    wreg(1, 7, 8'h40);
    rreg(1, 4, v);  check("R8 sync reg does not alias", v, 8'h00);
    wreg(1, 15, 8'h01);
    wreg(1, 7, 8'h40);
    rreg(1, 4, v);  check("R8 option reg aliases", v, 8'h11);
    wreg(1, 15, 8'h00);

    // R2: direct pointer low and point-high
    acc(0, 1'b0, 1'b1, 8'h05); acc(0, 1'b0, 1'b0, 8'h00); check("R2 ptr low", last_rd, 8'h5A);
    acc(0, 1'b0, 1'b1, 8'h0C); acc(0, 1'b0, 1'b0, 8'h00); check("R2 ptr high", last_rd, model[0][12]);

    // R11: data port leaves the pointer alone
    acc(0, 1'b0, 1'b1, 8'h0C);
    acc(0, 1'b1, 1'b1, 8'h12); check("R11 data tx A", {p_tx, p_txb}, {2'b01, 8'h12});
    acc(0, 1'b0, 1'b0, 8'h00); check("R11 ptr kept", last_rd, model[0][12]);
    acc(1, 1'b1, 1'b1, 8'h77); check("R11 data tx B", {p_tx, p_txb}, {2'b10, 8'h77});
    wreg(0, 8, 8'h5E);         check("R11 reg8 tx A", {p_tx, p_txb}, {2'b01, 8'h5E});
    acc(0, 1'b1, 1'b0, 8'h00); check("R11 data rx A", {p_rx, last_rd}, {2'b01, 8'hD3});
    rreg(1, 8, v);             check("R11 reg8 rx B", {p_rx, v}, {2'b10, 8'hC4});

    // R13: status inputs
    for (int c = 0; c < 2; c++) begin
      logic [7:0] hi;
      hi = c ? 8'hB0 : 8'hA0;
      acc(c[0], 1'b0, 1'b0, 8'h00); check("R13 rr0", last_rd, hi);
      rreg(c[0], 1, v);  check("R13 rr1", v, hi | 8'h01);
      rreg(c[0], 6, v);  check("R13 rr6", v, hi | 8'h06);
      rreg(c[0], 7, v);  check("R13 rr7", v, hi | 8'h07);
      rreg(c[0], 10, v); check("R13 rr10", v, hi | 8'h0A);
    end

    // R5 / R10: shared vector and pending sweep
    irq_pend = 6'h3F;
    wreg(1, 2, 8'h96);
    rreg(0, 2, v); check("R5 vec on A", v, 8'h96);
    rreg(1, 2, v); check("R5 vec B plain", v, 8'h96);
    wreg(0, 9, 8'h01);
    for (int p = 0; p < 64; p++) begin
      irq_pend = 6'(p);
      rreg(1, 2, v); check("R5 vec B modified", v, 8'h90 | (8'(exp_code(6'(p))) << 1));
      rreg(0, 3, v); check("R10 pend A", v, 8'(p));
      rreg(1, 3, v); check("R10 pend B", v, 8'h00);
    end

    // R6: reset commands
    wreg(0, 9, 8'h41); check("R6 ch B reset", {p_ra, p_rb, p_hw}, 3'b010);
    wreg(1, 9, 8'h81); check("R6 ch A reset", {p_ra, p_rb, p_hw}, 3'b100);
    wreg(0, 9, 8'hC1); check("R6 hw reset", {p_ra, p_rb, p_hw}, 3'b001);
    acc(0, 1'b0, 1'b1, 8'h00); check("R6 one cycle", {p_ra, p_rb, p_hw}, 3'b000);
    rreg(1, 2, v); check("R6 bit0 kept", v, 8'h9C);

    // R7: clock recovery commands
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 8; k++) begin
        wreg(c[0], 14, {3'(k), 5'h0A});
        if (k == 0) check("R7 no strobe", p_dpll, 2'b00);
        else        check("R7 strobe", {p_dpll, p_dpllc}, {2'(1 << c), 3'(k)});
      end

    // R12: command and CRC codes
    for (int c = 0; c < 2; c++)
      for (int k = 2; k < 8; k++)
        for (int r = 0; r < 4; r++) begin
          acc(c[0], 1'b0, 1'b1, {2'(r), 3'(k), 3'b000});
          check("R12 cmd", {p_cmd, p_cmdc}, {2'(1 << c), 3'(k)});
          check("R12 crc", {p_crc, p_crcc}, (r == 0) ? {2'b00, p_crcc} : {2'(1 << c), 2'(r)});
        end
    acc(1, 1'b0, 1'b1, 8'hC0);
    check("R12 crc only", {p_cmd, p_crc, p_crcc}, {2'b00, 2'b10, 2'b11});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule